// File: doc/BRIEF.md
# Magic Packet Pattern Detector

This block sits on the byte stream of an Ethernet receive path and looks for a wake-up pattern inside each frame. The pattern is a run of at least six FFh bytes followed at once by sixteen back-to-back copies of the station's 48-bit address. The pattern may start at any byte position in the frame. Bytes arrive one per cycle when `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last byte. `rx_good` reports, together with the last byte, whether the upstream CRC check passed.

When a complete pattern is found, the block remembers it until the frame ends. It then issues a single-cycle `wake` pulse, but only if the frame turned out good. All matching state is local to one frame. Detection is gated by `en`. The station address is a static input that is held constant while a frame is in flight.

Top module: `magic_wake_detector`

## Requirements
- R1: While `rst` is high and in the cycles after it, until a pattern completes, `wake` is low and all matching state is cleared.
- R2: A sync run is six or more consecutive FFh bytes. While the search is looking for sync, every FFh byte extends the run. Five FFh bytes followed by the address copies do not match.
- R3: The sync run must be followed immediately by sixteen consecutive copies of the address. Each copy is compared first byte `sta_addr[47:40]` and last byte `sta_addr[7:0]`. The same bytes in reversed order do not match.
- R4: The sync-plus-address pattern is found at any byte offset within the frame.
- R5: A byte that differs from the expected address byte aborts the address phase. If that byte is FFh, it counts as the first byte of a new sync run. Otherwise the sync count restarts from zero.
- R6: `wake` is asserted only for a frame whose last byte carries `rx_good` high. A frame that contains the pattern but ends bad produces no pulse.
- R7: `wake` is a pulse of exactly one cycle. It is high in the cycle that follows the clock edge on which the last byte (`rx_valid` and `rx_eof`) was accepted, and low in every other cycle.
- R8: A byte with `rx_valid` and `rx_sof` clears all matching state and any found pattern before it is examined. A pattern split across two frames never produces a pulse.
- R9: When `en` is low, no pulse is produced. Bytes accepted while `en` is low are discarded and clear the matching state, so a pattern interrupted by a low `en` does not match.
- R10: A pattern whose final address byte is the last byte of the frame still produces the pulse. Bytes that follow a completed pattern in the same frame do not cancel it.
- R11: Cycles with `rx_valid` low are ignored. Idle gaps between bytes neither advance nor break a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Detection enable |
| sta_addr | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| rx_valid | input | 1 | Byte on `rx_data` is valid this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | With `rx_valid`: first byte of a frame |
| rx_eof | input | 1 | With `rx_valid`: last byte of a frame |
| rx_good | input | 1 | With the last byte: frame passed CRC |
| wake | output | 1 | One-cycle registered wake pulse |

## Verification
The block produces one result per frame: the level of `wake` one cycle after the edge that accepts the frame's last byte. Every other cycle must show `wake` low. For each frame, the driver queues one expected level. The monitor registers the end-of-frame strobe itself and pops a queue entry exactly on the cycle after that strobe. On all remaining cycles it checks for a stray pulse, which covers the one-cycle pulse width and the absence of early or late pulses in a single rule.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  typedef enum logic {
    PH_SYNC = 1'b0,
    PH_ADDR = 1'b1
  } mpd_phase_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;

endpackage

// File: rtl/mpd_byte_cmp.sv
module mpd_byte_cmp #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES,
  localparam int SW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [SW-1:0]     sel,
  output logic              is_sync,
  output logic              addr_hit
);

  logic [BYTE_W-1:0] addr_byte [ADDR_BYTES];
  logic [BYTE_W-1:0] expected;

  // First byte on the wire sits in the most significant lane.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign addr_byte[g] = sta_addr[ADDR_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    expected = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (sel == SW'(k)) expected = addr_byte[k];
    end
  end

  assign is_sync  = (rx_data == {BYTE_W{1'b1}});
  assign addr_hit = (rx_data == expected);

endmodule

// File: rtl/mpd_seq_tracker.sv
module mpd_seq_tracker
  import mpd_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES,
  localparam int SW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int CW        = (REPEATS > 1) ? $clog2(REPEATS) : 1,
  localparam int RW        = $clog2(SYNC_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_sof,
  output logic              match_now
);

  localparam logic [SW-1:0] LAST_SEL  = SW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] LAST_COPY = CW'(REPEATS - 1);
  localparam logic [RW-1:0] RUN_FULL  = RW'(SYNC_LEN);

  mpd_phase_e      phase_q, c_phase, n_phase;
  logic [RW-1:0]   run_q,   c_run,   n_run;
  logic [SW-1:0]   sel_q,   c_sel,   n_sel;
  logic [CW-1:0]   copy_q,  c_copy,  n_copy;
  logic            restart;
  logic            is_sync;
  logic            addr_hit;

  // State as seen by the current byte: a new frame or a disabled cycle starts from scratch.
  always_comb begin
    restart = !en || (rx_valid && rx_sof);
    c_phase = restart ? PH_SYNC : phase_q;
    c_run   = restart ? '0 : run_q;
    c_sel   = restart ? '0 : sel_q;
    c_copy  = restart ? '0 : copy_q;
  end

  mpd_byte_cmp #(
    .BYTE_W     (BYTE_W),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_cmp (
    .sta_addr (sta_addr),
    .rx_data  (rx_data),
    .sel      (c_sel),
    .is_sync  (is_sync),
    .addr_hit (addr_hit)
  );

  always_comb begin
    n_phase   = c_phase;
    n_run     = c_run;
    n_sel     = c_sel;
    n_copy    = c_copy;
    match_now = 1'b0;
    if (en && rx_valid) begin
      if (c_phase == PH_ADDR) begin
        if (addr_hit) begin
          if (c_sel == LAST_SEL) begin
            n_sel = '0;
            if (c_copy == LAST_COPY) begin
              match_now = 1'b1;
              n_phase   = PH_SYNC;
              n_run     = '0;
              n_copy    = '0;
            end else begin
              n_copy = c_copy + 1'b1;
            end
          end else begin
            n_sel = c_sel + 1'b1;
          end
        end else begin
          n_phase = PH_SYNC;
          n_sel   = '0;
          n_copy  = '0;
          n_run   = is_sync ? RW'(1) : '0;
        end
      end else begin
        if (is_sync) begin
          if (c_run != RUN_FULL) n_run = c_run + 1'b1;
        end else if (c_run == RUN_FULL && addr_hit) begin
          n_phase = PH_ADDR;
          n_run   = '0;
          n_sel   = SW'(1);
          n_copy  = '0;
        end else begin
          n_run = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SYNC;
      run_q   <= '0;
      sel_q   <= '0;
      copy_q  <= '0;
    end else begin
      phase_q <= n_phase;
      run_q   <= n_run;
      sel_q   <= n_sel;
      copy_q  <= n_copy;
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_FULL) else $error("sync run counter overflow"); // R2

  AST_ADDR_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADDR && $past(phase_q) == PH_SYNC)
      |-> $past(run_q == RUN_FULL && en && rx_valid && !rx_sof)) else $error("address phase without full sync"); // R2

  AST_MISS_FF_RESYNC: assert property (@(posedge clk) disable iff (rst)
    (en && rx_valid && !rx_sof && phase_q == PH_ADDR && !addr_hit && is_sync)
      |=> (phase_q == PH_SYNC && run_q == RW'(1))) else $error("FFh mismatch did not seed sync"); // R5

  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase_q == PH_SYNC && run_q == '0)) else $error("state kept while disabled"); // R9

endmodule

// File: rtl/mpd_wake_gen.sv
module mpd_wake_gen (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rx_valid,
  input  logic rx_sof,
  input  logic rx_eof,
  input  logic rx_good,
  input  logic match_now,
  output logic wake
);

  logic pend_q;
  logic c_pend;
  logic pend_all;
  logic wake_q;

  always_comb begin
    c_pend   = (rx_valid && rx_sof) ? 1'b0 : pend_q;
    pend_all = c_pend || match_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= en && rx_valid && rx_eof && rx_good && pend_all;
      if (!en || (rx_valid && rx_eof)) pend_q <= 1'b0;
      else if (rx_valid)               pend_q <= pend_all;
    end
  end

  assign wake = wake_q;

  AST_SOF_DROPS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sof && !match_now) |=> !pend_q) else $error("pending survived frame start"); // R8

  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
    (en && pend_q && !rx_valid) |=> pend_q) else $error("pending lost on idle cycle"); // R11

endmodule

// File: rtl/magic_wake_detector.sv
module magic_wake_detector #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_good,
  output logic              wake
);

  logic match_now;

  mpd_seq_tracker #(
    .BYTE_W     (BYTE_W),
    .ADDR_BYTES (ADDR_BYTES),
    .SYNC_LEN   (SYNC_LEN),
    .REPEATS    (REPEATS)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sta_addr  (sta_addr),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_sof    (rx_sof),
    .match_now (match_now)
  );

  mpd_wake_gen u_wake (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .rx_good   (rx_good),
    .match_now (match_now),
    .wake      (wake)
  );

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake) else $error("wake wider than one cycle"); // R7

  AST_WAKE_ON_GOOD_END: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(rx_valid && rx_eof && rx_good)) else $error("wake without good frame end"); // R6

  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(en)) else $error("wake while disabled"); // R9

endmodule

// File: tb/magic_wake_detector_tb.sv
module magic_wake_detector_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [47:0] sta_addr = 48'h02_1A_3C_4D_5E_6F;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_sof = 1'b0;
  logic        rx_eof = 1'b0;
  logic        rx_good = 1'b0;
  logic        wake;

  always #4 clk = ~clk;

  magic_wake_detector u_dut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sta_addr (sta_addr),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .rx_good  (rx_good),
    .wake     (wake)
  );

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;

  exp_t        sb[$];
  byte unsigned fr[$];
  int          vectors = 0;
  int          fails = 0;
  int          gap_every = 0;
  int          en_low_idx = -1;
  bit          en_level = 1'b1;
  logic        eof_d = 1'b0;

  task automatic add_ff(int n);
    for (int i = 0; i < n; i++) fr.push_back(8'hFF);
  endtask

  task automatic add_fill(int n);
    for (int i = 0; i < n; i++) fr.push_back(8'(8'h10 + (i % 32)));
  endtask

  task automatic add_copies(int n, logic [47:0] a);
    for (int c = 0; c < n; c++)
      for (int b = 0; b < 6; b++) fr.push_back(a[47-8*b -: 8]);
  endtask

  task automatic add_copies_rev(int n, logic [47:0] a);
    for (int c = 0; c < n; c++)
      for (int b = 0; b < 6; b++) fr.push_back(a[8*b +: 8]);
  endtask

  // Driver: queue the expected result, then play the frame out.
  task automatic send(bit good, bit exp, string tag);
    exp_t e;
    e.exp = exp;
    e.tag = tag;
    sb.push_back(e);
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fr[i];
      rx_sof   = (i == 0);
      rx_eof   = (i == fr.size() - 1);
      rx_good  = good;
      en       = (i == en_low_idx) ? 1'b0 : en_level;
      if (gap_every > 0 && (i % gap_every) == 1 && i != fr.size() - 1) begin
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        en       = en_level;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof   = 1'b0;
    rx_eof   = 1'b0;
    rx_good  = 1'b0;
    en       = en_level;
    fr.delete();
  endtask

  // Monitor: result is due one cycle after the edge that took the last byte.
  always @(posedge clk) eof_d <= rx_valid && rx_eof && !rst;

  always @(negedge clk) begin
    if (!rst) begin
      if (eof_d) begin
        if (sb.size() == 0) begin
          vectors++;
          fails++;
          $display("FAIL R7: frame end with empty scoreboard, wake=%0b expected=none", wake);
        end else begin
          exp_t e;
          e = sb.pop_front();
          vectors++;
          if (wake !== e.exp) begin
            fails++;
            $display("FAIL %s: wake=%0b expected=%0b", e.tag, wake, e.exp);
          end
        end
      end else if (wake !== 1'b0) begin
        vectors++;
        fails++;
        $display("FAIL R7: wake=%0b outside the cycle after a frame end, expected=0", wake);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (wake !== 1'b0) begin
        fails++;
        $display("FAIL R1: wake=%0b during reset expected=0", wake);
      end
    end
    rst = 1'b0;
    en  = en_level;
    repeat (2) @(negedge clk);
    vectors++;
    if (wake !== 1'b0) begin
      fails++;
      $display("FAIL R1: wake=%0b after reset expected=0", wake);
    end

    // R3: basic pattern at start, trailing bytes
    add_ff(6); add_copies(16, sta_addr); add_fill(10);
    send(1'b1, 1'b1, "R3 basic");

    // R4 R11: offset 37 with idle gaps
    gap_every = 3;
    add_fill(37); add_ff(6); add_copies(16, sta_addr); add_fill(5);
    send(1'b1, 1'b1, "R4 R11 offset with gaps");
    gap_every = 0;

    // R6: bad frame
    add_fill(4); add_ff(6); add_copies(16, sta_addr); add_fill(4);
    send(1'b0, 1'b0, "R6 bad frame");

    // R2: short sync
    add_fill(4); add_ff(5); add_copies(16, sta_addr);
    send(1'b1, 1'b0, "R2 five FFh");

    // R2: long sync
    add_fill(2); add_ff(9); add_copies(16, sta_addr); add_fill(3);
    send(1'b1, 1'b1, "R2 nine FFh");

    // R3: only fifteen copies
    add_ff(6); add_copies(15, sta_addr); add_fill(8);
    send(1'b1, 1'b0, "R3 fifteen copies");

    // R3: reversed byte order
    add_ff(6); add_copies_rev(16, sta_addr); add_fill(2);
    send(1'b1, 1'b0, "R3 reversed order");

    // R5: non-FFh mismatch aborts, remainder has no sync
    add_ff(6); add_copies(3, sta_addr); fr.push_back(8'h99); add_copies(13, sta_addr);
    send(1'b1, 1'b0, "R5 mismatch abort");

    // R5: FFh mismatch seeds new sync
    add_ff(6); add_copies(1, sta_addr); fr.push_back(8'h02); fr.push_back(8'h1A);
    add_ff(6); add_copies(16, sta_addr); add_fill(1);
    send(1'b1, 1'b1, "R5 FFh mismatch resync");

    // R8: pattern split across two frames
    add_fill(3); add_ff(6); add_copies(8, sta_addr);
    send(1'b1, 1'b0, "R8 split first half");
    add_copies(8, sta_addr); add_fill(2);
    send(1'b1, 1'b0, "R8 split second half");

    // R9: whole frame disabled
    en_level = 1'b0;
    add_ff(6); add_copies(16, sta_addr);
    send(1'b1, 1'b0, "R9 disabled frame");
    en_level = 1'b1;

    // R9: enable dropped for one byte mid pattern
    en_low_idx = 6 + 6*5 + 2;
    add_ff(6); add_copies(16, sta_addr); add_fill(2);
    send(1'b1, 1'b0, "R9 enable dip");
    en_low_idx = -1;

    // R10: pattern ends on last byte
    add_fill(11); add_ff(6); add_copies(16, sta_addr);
    send(1'b1, 1'b1, "R10 ends on eof");

    // R10: trailing FFh and junk after a match
    add_ff(6); add_copies(16, sta_addr); add_ff(7); add_fill(9);
    send(1'b1, 1'b1, "R10 trailing bytes");

    // R3: a different station address
    sta_addr = 48'hA5_00_11_22_33_44;
    add_fill(5); add_ff(6); add_copies(16, 48'hA5_00_11_22_33_44);
    send(1'b1, 1'b1, "R3 new address");
    add_ff(6); add_copies(16, 48'h02_1A_3C_4D_5E_6F);
    send(1'b1, 1'b0, "R3 old address rejected");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d results never observed, expected=0", sb.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule